// File: doc/BRIEF.md
# Transmit Line Source Selector

This block chooses what is sent on the two transmit line rails of an E1/T1 line interface. A two-bit select picks one of four sources. The first is the user's transmit data. The second is a built-in pseudo-random test sequence. The third is a steady alternating one/zero pattern. The fourth is an unframed all-ones stream. A mode input picks E1 or T1 operation. The mode sets which pseudo-random sequence is produced and which zero-substitution line code is applied.

User data is taken on the rising or the falling transmit-clock edge, chosen by an edge-select input. User data is either dual-rail (already bipolar), which passes straight through, or single-rail NRZ, which is line-coded. Everything that is line-coded goes through one alternate-mark-inversion encoder. When substitution is enabled, that encoder replaces long zero runs with the HDB3 code (E1) or the B8ZS code (T1). A power-down input blanks the rails and drops the output-enable flag, which stands for the tri-stated driver.

All sources share one fixed-latency path, so a change of the select is seen at the next bit boundary. The rails are registered and do not glitch.

Top module: `tx_src_sel`

## Requirements
- R1: `src_sel` picks the source at each rising edge: 00 user data, 01 pseudo-random sequence, 10 alternating pattern, 11 all ones. A one is sent as a pulse (rails `10` = positive, `01` = negative); a zero is sent as `00`.
- R2: With `t1_mode`=0 the pseudo-random source is a 15-bit shift register with taps x^15+x^14+1. It starts at all ones after reset. It emits its top bit and then shifts left, feeding in bit14 XOR bit13. It advances on every edge, whether it is selected or not.
- R3: With `t1_mode`=1 the pseudo-random source is a 20-bit shift register with taps x^20+x^17+1. It starts at all ones and feeds in bit19 XOR bit16. Its output is forced to one whenever the 14 bits before it were all zero, so no run is longer than 14 zeros.
- R4: The alternating source emits 1 on the first edge after reset, then 0, 1, 0 and so on. It advances on every edge.
- R5: The all-ones source puts a pulse on every bit.
- R6: With `edge_sel`=0 the user inputs are taken as they were at the falling edge before the rising edge that uses them. With `edge_sel`=1 they are taken at that rising edge.
- R7: With source 00 and `nrz_mode`=0, the pair {`usr_pos`,`usr_neg`} passes to the rails unchanged. This clears the substitution zero count and leaves the polarity state alone.
- R8: Line-coded ones alternate in polarity. The first pulse after reset is positive. In NRZ user mode the data bit is `usr_pos`.
- R9: In E1 with substitution on, a fourth zero in a row becomes a violation pulse. If an odd number of pulses was sent since the last violation, the four zeros become 000V, with V the same polarity as the last pulse. If the number is even, they become B00V, with B and V both opposite to the last pulse. The pulse count restarts after each substitution.
- R10: In T1 with substitution on, an eighth zero in a row turns the eight zeros into 000VB0VB. The first V has the polarity of the last pulse, and the pulses then go opposite, opposite, same.
- R11: With `zs_dis`=1 no substitution occurs; zeros stay `00`.
- R12: If `pwr_dn` is high at a rising edge, then after that edge both rails are 0 and `line_en` is 0. Otherwise `line_en` is 1.
- R13: A bit taken at rising edge n appears on the rails just after rising edge n+8. This latency is the same for every source and mode.
- R14: While `rst_n` is low, both rails and `line_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t1_mode | input | 1 | 0 = E1, 1 = T1 |
| src_sel | input | 2 | Transmit source select |
| edge_sel | input | 1 | User-data sampling edge: 0 falling, 1 rising |
| nrz_mode | input | 1 | User data is single-rail NRZ when 1 |
| zs_dis | input | 1 | 1 disables zero substitution |
| pwr_dn | input | 1 | Transmitter power-down |
| usr_pos | input | 1 | User positive rail / NRZ data |
| usr_neg | input | 1 | User negative rail |
| line_pos | output | 1 | Positive line rail |
| line_neg | output | 1 | Negative line rail |
| line_en | output | 1 | Driver enabled (0 = tri-stated) |

## Verification
The checker watches four rules on every cycle. Power-down blanks the rails and the enable one edge later. The enable comes back when power-down is low. Both rails are never high together once the dual-rail passthrough has been idle longer than the pipeline depth. Every bit is a pulse once the all-ones source has filled the pipeline. The bench runs a bit-exact reference model over the whole output stream. It is the only check of pulse polarity, the two substitution codes, the pseudo-random sequences, the eight-edge latency and the difference between the two sampling edges.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        SRC_USER = 2'b00,
        SRC_PRBS = 2'b01,
        SRC_ALT  = 2'b10,
        SRC_ONES = 2'b11
    } src_e;

    // Rail pair {pos, neg}
    typedef logic [1:0] sym_t;

    localparam sym_t SYM_ZERO = 2'b00;
    localparam sym_t SYM_POS  = 2'b10;
    localparam sym_t SYM_NEG  = 2'b01;

    function automatic sym_t pulse(input logic positive);
        return positive ? SYM_POS : SYM_NEG;
    endfunction

endpackage

// File: rtl/txs_capture.sv
module txs_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_sel,
    input  logic d_pos,
    input  logic d_neg,
    output logic s_pos,
    output logic s_neg
);
    logic [1:0] fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 2'b00;
        else        fall_q <= {d_pos, d_neg};
    end

    always_comb begin
        {s_pos, s_neg} = edge_sel ? {d_pos, d_neg} : fall_q;
    end
endmodule

// File: rtl/txs_lfsr.sv
module txs_lfsr #(
    parameter int unsigned WIDTH = 15,
    parameter int unsigned TAP   = 13,
    parameter int unsigned ZMAX  = 0
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_o
);
    logic [WIDTH-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = {reg_q[WIDTH-2:0], reg_q[WIDTH-1] ^ reg_q[TAP]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '1;
        else        reg_q <= reg_d;
    end

    generate
        if (ZMAX > 0) begin : g_zlimit
            localparam int unsigned ZW = $clog2(ZMAX + 1);
            logic [ZW-1:0] zc_d, zc_q;

            always_comb begin
                bit_o = reg_q[WIDTH-1] | (zc_q == ZW'(ZMAX));
                zc_d  = bit_o ? '0 : zc_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) zc_q <= '0;
                else        zc_q <= zc_d;
            end
        end else begin : g_plain
            always_comb bit_o = reg_q[WIDTH-1];
        end
    endgenerate
endmodule

// File: rtl/txs_encoder.sv
module txs_encoder
    import txs_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic t1_mode,
    input  logic zs_en,
    input  logic bypass,
    input  logic bit_in,
    input  sym_t rail_in,
    output sym_t sym_o
);
    localparam logic [2:0] HDB_RUN = 3'd3;
    localparam logic [2:0] B8_RUN  = 3'd7;

    typedef struct packed {
        sym_t [DEPTH-1:0] line;
        logic [2:0]       zrun;
        logic             lpol;
        logic             par;
    } enc_t;

    enc_t d, q;

    always_comb begin
        d = q;
        for (int i = DEPTH - 1; i > 0; i--) begin
            d.line[i] = q.line[i-1];
        end
        d.line[0] = SYM_ZERO;
        if (bypass) begin
            d.line[0] = rail_in;
            d.zrun    = 3'd0;
        end else if (bit_in) begin
            d.line[0] = pulse(~q.lpol);
            d.lpol    = ~q.lpol;
            d.par     = ~q.par;
            d.zrun    = 3'd0;
        end else if (!zs_en) begin
            d.zrun    = 3'd0;
        end else if (!t1_mode && q.zrun >= HDB_RUN) begin
            if (q.par) begin
                d.line[0] = pulse(q.lpol);
            end else begin
                d.line[3] = pulse(~q.lpol);
                d.line[0] = pulse(~q.lpol);
                d.lpol    = ~q.lpol;
            end
            d.par  = 1'b0;
            d.zrun = 3'd0;
        end else if (t1_mode && q.zrun >= B8_RUN) begin
            d.line[4] = pulse(q.lpol);
            d.line[3] = pulse(~q.lpol);
            d.line[1] = pulse(~q.lpol);
            d.line[0] = pulse(q.lpol);
            d.zrun    = 3'd0;
        end else begin
            d.zrun = (q.zrun == B8_RUN) ? q.zrun : q.zrun + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sym_o = q.line[DEPTH-1];
endmodule

// File: rtl/tx_src_sel.sv
module tx_src_sel
    import txs_pkg::*;
#(
    parameter int unsigned E1_LEN     = 15,
    parameter int unsigned E1_TAP     = 13,
    parameter int unsigned T1_LEN     = 20,
    parameter int unsigned T1_TAP     = 16,
    parameter int unsigned T1_ZMAX    = 14,
    parameter int unsigned LINE_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       t1_mode,
    input  logic [1:0] src_sel,
    input  logic       edge_sel,
    input  logic       nrz_mode,
    input  logic       zs_dis,
    input  logic       pwr_dn,
    input  logic       usr_pos,
    input  logic       usr_neg,
    output logic       line_pos,
    output logic       line_neg,
    output logic       line_en
);
    typedef struct packed {
        logic alt;
        sym_t rails;
        logic en;
    } top_t;

    top_t d, q;
    logic s_pos, s_neg, e1_bit, t1_bit, bypass, nrz_bit;
    sym_t enc_sym;
    src_e src;

    txs_capture u_cap (
        .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel),
        .d_pos(usr_pos), .d_neg(usr_neg), .s_pos(s_pos), .s_neg(s_neg)
    );

    txs_lfsr #(.WIDTH(E1_LEN), .TAP(E1_TAP), .ZMAX(0)) u_e1_prbs (
        .clk(clk), .rst_n(rst_n), .bit_o(e1_bit)
    );

    txs_lfsr #(.WIDTH(T1_LEN), .TAP(T1_TAP), .ZMAX(T1_ZMAX)) u_t1_prbs (
        .clk(clk), .rst_n(rst_n), .bit_o(t1_bit)
    );

    always_comb begin
        src     = src_e'(src_sel);
        bypass  = (src == SRC_USER) && !nrz_mode;
        case (src)
            SRC_USER: nrz_bit = s_pos;
            SRC_PRBS: nrz_bit = t1_mode ? t1_bit : e1_bit;
            SRC_ALT:  nrz_bit = q.alt;
            SRC_ONES: nrz_bit = 1'b1;
            default:  nrz_bit = 1'b0;
        endcase
    end

    txs_encoder #(.DEPTH(LINE_DEPTH)) u_enc (
        .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .zs_en(!zs_dis),
        .bypass(bypass), .bit_in(nrz_bit), .rail_in({s_pos, s_neg}),
        .sym_o(enc_sym)
    );

    always_comb begin
        d       = q;
        d.alt   = ~q.alt;
        d.en    = ~pwr_dn;
        d.rails = pwr_dn ? SYM_ZERO : enc_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{alt: 1'b1, rails: SYM_ZERO, en: 1'b0};
        else        q <= d;
    end

    assign {line_pos, line_neg} = q.rails;
    assign line_en              = q.en;
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_sel,
    input logic       nrz_mode,
    input logic       pwr_dn,
    input logic       line_pos,
    input logic       line_neg,
    input logic       line_en
);
    logic [3:0] bp_age, ones_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_age   <= 4'd0;
            ones_age <= 4'd0;
        end else begin
            if (src_sel == 2'b00 && !nrz_mode) bp_age <= 4'd0;
            else if (bp_age != 4'd15)          bp_age <= bp_age + 4'd1;
            if (src_sel != 2'b11)              ones_age <= 4'd0;
            else if (ones_age != 4'd15)        ones_age <= ones_age + 4'd1;
        end
    end

    a_r12_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_dn) |-> (!line_en && !line_pos && !line_neg));

    a_r12_en_live: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pwr_dn) && $past(rst_n)) |-> line_en);

    a_r8_single_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_age >= 4'd9) |-> !(line_pos && line_neg));

    a_r5_ones_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_age >= 4'd9 && line_en) |-> (line_pos != line_neg));
endmodule

bind tx_src_sel txs_checker i_chk (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .nrz_mode(nrz_mode),
    .pwr_dn(pwr_dn), .line_pos(line_pos), .line_neg(line_neg), .line_en(line_en)
);

// File: tb/test_tx_src_sel.sv
module test_tx_src_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t1_mode = 1'b0, edge_sel = 1'b1, nrz_mode = 1'b0, zs_dis = 1'b1;
    logic pwr_dn = 1'b0, usr_pos = 1'b0, usr_neg = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic line_pos, line_neg, line_en;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R14";

    always #4 clk = ~clk;

    tx_src_sel i_tx_src_sel (
        .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .src_sel(src_sel),
        .edge_sel(edge_sel), .nrz_mode(nrz_mode), .zs_dis(zs_dis), .pwr_dn(pwr_dn),
        .usr_pos(usr_pos), .usr_neg(usr_neg),
        .line_pos(line_pos), .line_neg(line_neg), .line_en(line_en)
    );

    // Reference model state
    logic [14:0] m_e1;
    logic [19:0] m_t1;
    int m_qz, m_zr;
    logic m_alt, m_lp, m_pr, np, nn;
    logic [1:0] sq[$];
    logic [1:0] exp_sym[$];
    logic exp_en[$];
    string exp_tag[$];

    function automatic logic [1:0] pl(input logic p);
        return p ? 2'b10 : 2'b01;
    endfunction

    always @(negedge clk) begin
        np = usr_pos;
        nn = usr_neg;
    end

    // Driver side: predicts the rails for each edge and queues them
    always @(posedge clk) begin
        logic e1b, t1b, ab, sp, sn, b, byp;
        logic [1:0] e;
        if (!rst_n) begin
            m_e1 = '1; m_t1 = '1; m_qz = 0; m_alt = 1; m_zr = 0; m_lp = 0; m_pr = 0;
            sq.delete();
            repeat (8) sq.push_back(2'b00);
        end else begin
            e1b = m_e1[14];
            t1b = m_t1[19] | (m_qz >= 14);
            m_qz = t1b ? 0 : m_qz + 1;
            m_e1 = {m_e1[13:0], m_e1[14] ^ m_e1[13]};
            m_t1 = {m_t1[18:0], m_t1[19] ^ m_t1[16]};
            ab = m_alt; m_alt = ~m_alt;
            sp = edge_sel ? usr_pos : np;
            sn = edge_sel ? usr_neg : nn;
            byp = 0; b = 0;
            case (src_sel)
                2'b00: if (nrz_mode) b = sp; else byp = 1;
                2'b01: b = t1_mode ? t1b : e1b;
                2'b10: b = ab;
                default: b = 1;
            endcase
            if (byp) begin
                sq.push_back({sp, sn}); m_zr = 0;
            end else if (b) begin
                m_lp = ~m_lp; m_pr = ~m_pr; sq.push_back(pl(m_lp)); m_zr = 0;
            end else begin
                sq.push_back(2'b00);
                if (zs_dis) m_zr = 0;
                else if (!t1_mode && m_zr >= 3) begin
                    if (m_pr) sq[sq.size()-1] = pl(m_lp);
                    else begin
                        sq[sq.size()-4] = pl(~m_lp);
                        sq[sq.size()-1] = pl(~m_lp);
                        m_lp = ~m_lp;
                    end
                    m_pr = 0; m_zr = 0;
                end else if (t1_mode && m_zr >= 7) begin
                    sq[sq.size()-5] = pl(m_lp);
                    sq[sq.size()-4] = pl(~m_lp);
                    sq[sq.size()-2] = pl(~m_lp);
                    sq[sq.size()-1] = pl(m_lp);
                    m_zr = 0;
                end else if (m_zr < 7) m_zr = m_zr + 1;
            end
            e = sq.pop_front();
            exp_sym.push_back(pwr_dn ? 2'b00 : e);
            exp_en.push_back(!pwr_dn);
            exp_tag.push_back(tag);
        end
    end

    // Monitor side: compares each produced rail pair
    always @(posedge clk) begin
        logic [1:0] es;
        logic ee;
        string et;
        #2;
        if (exp_sym.size() > 0) begin
            es = exp_sym.pop_front(); ee = exp_en.pop_front(); et = exp_tag.pop_front();
            checks++;
            if ({line_pos, line_neg} !== es || line_en !== ee) begin
                errors++;
                $display("FAIL %s: rails=%b%b en=%b expected rails=%b en=%b",
                         et, line_pos, line_neg, line_en, es, ee);
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            step(); usr_pos = w[i];
        end
    endtask

    task automatic send_split(input logic a, input logic b2);
        step(); usr_pos = a; usr_neg = ~a;
        @(negedge clk); #1; usr_pos = b2; usr_neg = ~b2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
    end

    initial begin
        // R14: reset state
        repeat (3) @(posedge clk);
        #2;
        for (int k = 0; k < 3; k++) begin
            checks++;
            if ({line_pos, line_neg, line_en} !== 3'b000) begin
                errors++;
                $display("FAIL R14: outputs=%b expected 000", {line_pos, line_neg, line_en});
            end
            #1;
        end
        @(posedge clk); #3; rst_n = 1'b1;

        tag = "R4 R8 R13"; src_sel = 2'b10; zs_dis = 1'b0;
        repeat (40) step();
        tag = "R5"; src_sel = 2'b11;
        repeat (40) step();
        tag = "R2 R11"; src_sel = 2'b01; zs_dis = 1'b1;
        repeat (300) step();
        tag = "R2 R9"; zs_dis = 1'b0;
        repeat (300) step();
        tag = "R9 R8"; src_sel = 2'b00; nrz_mode = 1'b1;
        send_word(32'b1000_0100_0011_0000_0001_1000_0000_0001);
        send_word(32'b0000_0000_1100_0010_0000_1000_0000_0000);
        send_word(32'b1010_0000_0000_0000_1110_0001_0000_0000);
        tag = "R10"; t1_mode = 1'b1;
        send_word(32'b1000_0000_0100_0000_0001_1000_0000_0000);
        send_word(32'b0000_0000_0000_0000_1011_0000_0001_0000);
        tag = "R11"; zs_dis = 1'b1;
        send_word(32'b1000_0000_0000_0000_0100_0010_0000_0001);
        tag = "R7"; nrz_mode = 1'b0;
        for (int i = 0; i < 24; i++) begin
            step(); usr_pos = i[0]; usr_neg = i[1];
        end
        tag = "R6"; edge_sel = 1'b0;
        for (int i = 0; i < 12; i++) send_split(i[0], ~i[0]);
        edge_sel = 1'b1;
        for (int i = 0; i < 12; i++) send_split(i[1], ~i[1]);
        tag = "R12"; src_sel = 2'b11; nrz_mode = 1'b1; zs_dis = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step(); pwr_dn = (i % 7) < 3;
        end
        step(); pwr_dn = 1'b0;
        tag = "R1 R13"; t1_mode = 1'b0;
        for (int i = 0; i < 64; i++) begin
            step(); src_sel = i[1:0] ^ i[3:2]; usr_pos = i[2];
        end
        tag = "R3 R10"; t1_mode = 1'b1; src_sel = 2'b01;
        repeat (120000) step();
        tag = "R5 R13"; src_sel = 2'b11;
        repeat (12) step();
        @(posedge clk); #3;
        summary();
    end
endmodule